// File: doc/BRIEF.md
# Two-Level Interrupt Context Shadow Saver

This block sits beside a processor core's interrupt controller and saves the core's working registers without spending any instructions or cycles on it. It watches a flat vector of the core's live registers, a low-priority and a high-priority interrupt request, a global enable and a return-from-interrupt strobe. When a request is accepted, the block raises an entry strobe in the same cycle. At that clock edge it copies the live registers into a shadow bank owned by the accepted level.

On a return strobe, the block presents the saved contents of the most recently entered level, with a restore-valid strobe, in that same cycle. The core writes them back, and the level's active flag is cleared at the edge. Each level has its own bank, so a high-priority handler can pre-empt a low-priority one without disturbing the low-priority save.

A parameter selects a single-level build, which has one bank and no nesting. In that build either request line enters the only level, and any request that arrives while the handler runs waits until the return.

Top module: `ctx_shadow_saver`

## Requirements
- R1: An accepted request raises `take_o` combinationally in the cycle it is presented, with `take_lvl_o` = 1 for high and 0 for low. At that clock edge the live registers are stored into that level's bank, and the level's `active_o` bit is set (bit 0 = low level, bit 1 = high level).
- R2: When `ret_i` is high and a handler is active, `restore_en_o` is high in the same cycle. `restore_o` then carries the bank of the most recently entered level (high if `active_o[1]` is set, else low). That level's `active_o` bit clears at the edge.
- R3: A high request pre-empts a running low handler with zero wait. The low bank keeps its contents, and it is restored unchanged after the high handler returns.
- R4: No request is accepted at a level whose own handler or a higher level's handler is active. Such a request stays pending, and it is taken once that handler returns.
- R5: When high and low requests arrive in the same cycle, high is taken and low stays pending.
- R6: While `gie_i` is low, no request is accepted.
- R7: A return with no active handler gives no `restore_en_o` and leaves `active_o` unchanged.
- R8: No request is accepted in a cycle in which `ret_i` is high.
- R9: With `NUM_LEVELS` = 1, either request line enters the single level (`take_lvl_o` = 0). A request during the handler stays pending until the return.
- R10: After reset, `active_o` is 0 and `take_o` and `restore_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| live_i | input | NUM_REGS*REG_W | Core working registers, register 0 in the low bits |
| gie_i | input | 1 | Global interrupt enable |
| irq_lo_i | input | 1 | Low-priority interrupt request |
| irq_hi_i | input | 1 | High-priority interrupt request |
| ret_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | Request accepted this cycle |
| take_lvl_o | output | 1 | Level accepted: 1 high, 0 low |
| restore_en_o | output | 1 | Restore data valid this cycle |
| restore_o | output | NUM_REGS*REG_W | Saved registers to write back |
| active_o | output | 2 | Handlers in progress: bit 1 high, bit 0 low |

## Verification
Assertions check the following properties on every cycle:
- at most one level is taken at a time;
- nothing is accepted with the enable low or during a return;
- a low entry is never accepted while the high level is active;
- an entry sets its active bit, and a return clears the top bit;
- an idle return never restores;
- a bank changes only on its own write strobe.

Only the bench scenarios can show that the restored data equals what was live at the matching entry. Those scenarios use a scoreboard that follows the nesting order. The same holds for showing that pending requests are taken after the return, and that the single-level build defers any request made during its handler.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;
   localparam int MAX_LEVELS = 2;
   typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} ctx_lvl_e;
endpackage

// File: rtl/ctx_accept_arb.sv
module ctx_accept_arb #(
   parameter int NUM_LEVELS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gie_i,
   input  logic       irq_hi_i,
   input  logic       irq_lo_i,
   input  logic       ret_i,
   input  logic [1:0] active_i,
   output logic       take_hi_o,
   output logic       take_lo_o
);
   logic open_gate;
   assign open_gate = gie_i & ~ret_i;

   generate
      if (NUM_LEVELS == 2) begin : g_two
         // high waits only on its own level; low waits on both
         assign take_hi_o = open_gate & irq_hi_i & ~active_i[1];
         assign take_lo_o = open_gate & irq_lo_i & ~irq_hi_i & ~(|active_i);
      end else begin : g_one
         assign take_hi_o = 1'b0;
         assign take_lo_o = open_gate & (irq_hi_i | irq_lo_i) & ~(|active_i);
      end
   endgenerate

   p_one_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({take_hi_o, take_lo_o}));
   p_gie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> !(take_hi_o || take_lo_o));
   p_ret_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i |-> !(take_hi_o || take_lo_o));
endmodule

// File: rtl/ctx_nest_tracker.sv
module ctx_nest_tracker (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_hi_i,
   input  logic       take_lo_i,
   input  logic       ret_i,
   output logic [1:0] active_o
);
   logic [1:0] active_q, active_d;

   always_comb begin
      active_d = active_q;
      if (ret_i) begin
         if (active_q[1]) active_d[1] = 1'b0;
         else             active_d[0] = 1'b0;
      end
      if (take_hi_i) active_d[1] = 1'b1;
      if (take_lo_i) active_d[0] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= '0;
      else        active_q <= active_d;
   end

   assign active_o = active_q;

   p_entry_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take_lo_i |=> active_q[0]);
   p_ret_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && active_q[1]) |=> !active_q[1]);
   p_lo_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      active_q[1] |-> !take_lo_i);
endmodule

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank #(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] rd_data_o
);
   logic [WIDTH-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (wr_en_i) data_q <= wr_data_i;
   end

   assign rd_data_o = data_q;

   p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(data_q));
endmodule

// File: rtl/ctx_shadow_saver.sv
module ctx_shadow_saver
   import ctx_shadow_pkg::*;
#(
   parameter int NUM_REGS   = 8,
   parameter int REG_W      = 8,
   parameter int NUM_LEVELS = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REGS*REG_W-1:0] live_i,
   input  logic                      gie_i,
   input  logic                      irq_lo_i,
   input  logic                      irq_hi_i,
   input  logic                      ret_i,
   output logic                      take_o,
   output logic                      take_lvl_o,
   output logic                      restore_en_o,
   output logic [NUM_REGS*REG_W-1:0] restore_o,
   output logic [1:0]                active_o
);
   localparam int CTX_W = NUM_REGS * REG_W;

   generate
      if (NUM_LEVELS < 1 || NUM_LEVELS > MAX_LEVELS) begin : g_bad_levels
         $error("ctx_shadow_saver: NUM_LEVELS must be 1 or 2");
      end
      if (NUM_REGS < 1 || REG_W < 1) begin : g_bad_width
         $error("ctx_shadow_saver: NUM_REGS and REG_W must be positive");
      end
   endgenerate

   logic             take_hi, take_lo;
   logic [1:0]       active;
   logic [CTX_W-1:0] bank_rd [NUM_LEVELS];
   ctx_lvl_e         ret_lvl;

   ctx_accept_arb #(.NUM_LEVELS(NUM_LEVELS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .gie_i     (gie_i),
      .irq_hi_i  (irq_hi_i),
      .irq_lo_i  (irq_lo_i),
      .ret_i     (ret_i),
      .active_i  (active),
      .take_hi_o (take_hi),
      .take_lo_o (take_lo)
   );

   ctx_nest_tracker u_nest (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_hi_i (take_hi),
      .take_lo_i (take_lo),
      .ret_i     (ret_i),
      .active_o  (active)
   );

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_bank
      logic wr_en;
      assign wr_en = (l == int'(LVL_HI)) ? take_hi : take_lo;
      ctx_shadow_bank #(.WIDTH(CTX_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en_i   (wr_en),
         .wr_data_i (live_i),
         .rd_data_o (bank_rd[l])
      );
   end

   assign ret_lvl = active[1] ? LVL_HI : LVL_LO;

   generate
      if (NUM_LEVELS == 2) begin : g_mux2
         assign restore_o = (ret_lvl == LVL_HI) ? bank_rd[1] : bank_rd[0];
      end else begin : g_mux1
         assign restore_o = bank_rd[0];
      end
   endgenerate

   assign take_o       = take_hi | take_lo;
   assign take_lvl_o   = take_hi;
   assign restore_en_o = ret_i & (|active);
   assign active_o     = active;

   p_idle_no_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active == 2'b00) |-> !restore_en_o);
   p_take_marks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && take_lvl_o) |=> active_o[1]);
endmodule

// File: tb/ctx_shadow_saver_tb_top.sv
`timescale 1ns/1ps
module ctx_shadow_saver_tb_top;
   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] live = '0;
   logic         gie = 1'b0, irq_lo = 1'b0, irq_hi = 1'b0, ret = 1'b0;
   logic         take0, lvl0, ren0, take1, lvl1, ren1;
   logic [W-1:0] rst0, rst1;
   logic [1:0]   act0, act1;
   logic         sel = 1'b0;

   int errors = 0;
   int checks = 0;
   logic [W-1:0] stk[$];
   logic [W-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   ctx_shadow_saver dut_i (
      .clk(clk), .rst_n(rst_n), .live_i(live), .gie_i(gie), .irq_lo_i(irq_lo),
      .irq_hi_i(irq_hi), .ret_i(ret), .take_o(take0), .take_lvl_o(lvl0),
      .restore_en_o(ren0), .restore_o(rst0), .active_o(act0));

   ctx_shadow_saver #(.NUM_LEVELS(1)) dut1_i (
      .clk(clk), .rst_n(rst_n), .live_i(live), .gie_i(gie), .irq_lo_i(irq_lo),
      .irq_hi_i(irq_hi), .ret_i(ret), .take_o(take1), .take_lvl_o(lvl1),
      .restore_en_o(ren1), .restore_o(rst1), .active_o(act1));

   wire         s_take = sel ? take1 : take0;
   wire         s_lvl  = sel ? lvl1  : lvl0;
   wire         s_ren  = sel ? ren1  : ren0;
   wire [W-1:0] s_rst  = sel ? rst1  : rst0;
   wire [1:0]   s_act  = sel ? act1  : act0;

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every restore must match the next expected item
   always @(negedge clk) begin
      if (rst_n && s_ren) begin
         if (exp_q.size() == 0) chk("R7 unexpected restore", 1, 0);
         else chk("R2 restored context", s_rst, exp_q.pop_front());
      end
   end

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; gie = 0; irq_hi = 0; irq_lo = 0; ret = 0;
      stk.delete(); exp_q.delete();
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
   endtask

   // driver: drives one cycle, updates the model, checks the entry strobe
   task automatic step(string req, logic g, logic h, logic l, logic r,
                       logic [W-1:0] v, logic e_take, logic e_lvl);
      @(posedge clk); #1;
      gie = g; irq_hi = h; irq_lo = l; ret = r; live = v;
      if (r && stk.size() > 0) exp_q.push_back(stk.pop_back());
      if (e_take) stk.push_back(v);
      @(negedge clk);
      chk({req, " take"}, W'(s_take), W'(e_take));
      if (e_take) chk({req, " level"}, W'(s_lvl), W'(e_lvl));
   endtask

   task automatic idle_chk(string req, logic [1:0] e_act);
      step(req, 0, 0, 0, 0, live, 0, 0);
      chk({req, " active"}, W'(s_act), W'(e_act));
   endtask

   initial begin
      #1_000_000;
      chk("watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      sel = 1'b0;
      do_reset();
      chk("R10 active", W'(s_act), 0);
      chk("R10 take", W'(s_take), 0);
      chk("R10 restore_en", W'(s_ren), 0);

      step("R1 low entry", 1, 0, 1, 0, 64'hA1A2A3A4A5A6A7A8, 1, 0);
      idle_chk("R1 low active", 2'b01);
      step("R3 high preempt", 1, 1, 0, 0, 64'hB1B2B3B4B5B6B7B8, 1, 1);
      step("R4 low blocked", 1, 0, 1, 0, 64'hC0C0C0C0C0C0C0C0, 0, 0);
      chk("R4 nest active", W'(s_act), 2'b11);
      step("R4 high blocked", 1, 1, 0, 0, 64'hC0C0C0C0C0C0C0C0, 0, 0);
      step("R2 high return", 1, 0, 0, 1, 64'hD0D0D0D0D0D0D0D0, 0, 0);
      idle_chk("R2 high cleared", 2'b01);
      step("R3 low return", 1, 0, 0, 1, 64'hE0E0E0E0E0E0E0E0, 0, 0);
      idle_chk("R3 low cleared", 2'b00);

      step("R6 gie low", 0, 1, 1, 0, 64'h1111111111111111, 0, 0);
      idle_chk("R6 nothing active", 2'b00);
      step("R7 idle return", 1, 0, 0, 1, 64'h2222222222222222, 0, 0);
      chk("R7 no restore", W'(s_ren), 0);
      idle_chk("R7 state kept", 2'b00);

      step("R5 both requests", 1, 1, 1, 0, 64'hF1F2F3F4F5F6F7F8, 1, 1);
      step("R5 low pending", 1, 0, 1, 0, 64'h3333333333333333, 0, 0);
      step("R8 return with low held", 1, 0, 1, 1, 64'h4444444444444444, 0, 0);
      step("R5 low taken after", 1, 0, 1, 0, 64'h5555555555555555, 1, 0);
      step("R2 low return", 1, 0, 0, 1, 64'h6666666666666666, 0, 0);

      step("R1 low entry again", 1, 0, 1, 0, 64'h0123456789ABCDEF, 1, 0);
      step("R8 high during return", 1, 1, 0, 1, 64'h7777777777777777, 0, 0);
      step("R8 high taken after", 1, 1, 0, 0, 64'h8888888888888888, 1, 1);
      step("R2 high alone return", 1, 0, 0, 1, 64'h9999999999999999, 0, 0);
      idle_chk("R2 all cleared", 2'b00);

      sel = 1'b1;
      do_reset();
      chk("R10 single active", W'(s_act), 0);
      step("R9 single entry", 1, 0, 1, 0, 64'hFEDCBA9876543210, 1, 0);
      step("R9 high pending", 1, 1, 0, 0, 64'hAAAA5555AAAA5555, 0, 0);
      chk("R9 single active", W'(s_act), 2'b01);
      step("R9 single return", 1, 1, 0, 1, 64'h5555AAAA5555AAAA, 0, 0);
      step("R9 high on only level", 1, 1, 0, 0, 64'h0F0F0F0F0F0F0F0F, 1, 0);
      step("R9 second return", 1, 0, 0, 1, 64'hF0F0F0F0F0F0F0F0, 0, 0);
      idle_chk("R9 single cleared", 2'b00);

      chk("R2 scoreboard drained", W'(exp_q.size()), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule